// File: doc/BRIEF.md
# Single-Precision Comparator with Condition Flags

This block compares two IEEE 754 binary32 operands, a left operand `d` and a right operand `m`, and produces a 4-bit processor condition result and an invalid-operation indication. It works only on the packed 32-bit encodings. It does not unpack either operand and does no arithmetic on it. The order of two numbers comes from an unsigned compare of their magnitude bits, and the sign bits decide which way that result is read.

Two per-request controls give the four compare variants. A signal-on-quiet input makes quiet NaNs raise invalid as well. A compare-with-zero input replaces `m` with positive zero.

Each request is given as a one-cycle `valid_i` strobe. The result is registered and appears one cycle later. It then holds until the next request.

The flag bits are ordered N (bit 3), Z (bit 2), C (bit 1) and V (bit 0). The block produces four outcome codes:

| Outcome | Flags |
|---------|-------|
| less | `4'b1000` |
| equal | `4'b0110` |
| greater | `4'b0010` |
| unordered | `4'b0011` |

Top module: `fcmp_flags`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its mantissa (bits 22:0) is nonzero. If either operand is a NaN, the result is unordered, `4'b0011`.
- R2: A NaN whose mantissa bit 22 is clear is signalling. A signalling NaN in either operand always sets `invalid_o`.
- R3: A quiet NaN (mantissa bit 22 set) sets `invalid_o` only when `sig_quiet_i` is 1. Otherwise `invalid_o` is 0.
- R4: Two operands are equal when their bit patterns match, or when both are zeros of any sign. The equal result is `4'b0110`.
- R5: When the sign bits (bit 31) differ and the operands are not equal, a negative `d` gives less, `4'b1000`. A positive `d` gives greater, `4'b0010`.
- R6: When the signs match, the magnitude bits are compared as unsigned integers. For two positive operands, a smaller `d` gives less. For two negative operands the sense is inverted. Infinities and denormals follow the same rule.
- R7: When `cmp_zero_i` is 1, `m` is taken as `+0` (`32'h0`), and `m_i` has no effect on the result.
- R8: Every result is exactly one of the four codes (less, equal, greater, unordered). `invalid_o` can be 1 only with the unordered code.
- R9: The result appears on `flags_o` and `invalid_o` in the cycle after `valid_i`, with `valid_o` high for one cycle. With no request, all outputs hold their values.
- R10: After reset, `valid_o`, `flags_o` and `invalid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Compare request strobe |
| d_i | input | 32 | Left operand, binary32 encoding |
| m_i | input | 32 | Right operand, binary32 encoding |
| cmp_zero_i | input | 1 | Compare `d_i` against +0 instead of `m_i` |
| sig_quiet_i | input | 1 | Quiet NaNs also raise invalid |
| valid_o | output | 1 | Result valid, one cycle after request |
| flags_o | output | 4 | Condition result {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation indication |

## Verification
The only state in this block is the result register, so any fault in the classify or order logic shows on `flags_o` one cycle after the request that exposes it. A wrong NaN decode appears as an unordered code on an ordinary number, or as an ordered code on a NaN. A wrong sign correction reverses less and greater only for pairs of negative operands, so both sign polarities and both zero signs need to be exercised. A fault in the hold path shows as a changed output on idle cycles.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned MAN_W  = 23;
  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;
  localparam int unsigned FLAG_W = 4;

  // {N,Z,C,V}
  localparam logic [FLAG_W-1:0] FL_LT  = 4'b1000;
  localparam logic [FLAG_W-1:0] FL_EQ  = 4'b0110;
  localparam logic [FLAG_W-1:0] FL_GT  = 4'b0010;
  localparam logic [FLAG_W-1:0] FL_UNO = 4'b0011;

  typedef struct packed {
    logic nan;
    logic snan;
  } op_class_t;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2
  } order_e;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W
) (
  input  logic [EW+MW:0] word_i,
  output op_class_t      cls_o
);
  localparam int unsigned QBIT = MW - 1;

  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;

  assign exp_f = word_i[EW+MW-1:MW];
  assign man_f = word_i[MW-1:0];

  always_comb begin
    cls_o.nan  = (&exp_f) && (|man_f);
    cls_o.snan = cls_o.nan && !man_f[QBIT];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] m_i,
  output order_e       ord_o
);
  localparam int unsigned MAG_W = W - 1;

  logic             d_neg, m_neg;
  logic [MAG_W-1:0] d_mag, m_mag;
  logic             both_zero, mag_lt;

  assign d_neg     = d_i[W-1];
  assign m_neg     = m_i[W-1];
  assign d_mag     = d_i[MAG_W-1:0];
  assign m_mag     = m_i[MAG_W-1:0];
  assign both_zero = ~|(d_mag | m_mag);
  assign mag_lt    = d_mag < m_mag;

  always_comb begin
    if (d_i == m_i || both_zero) begin
      ord_o = ORD_EQ;
    end else if (d_neg != m_neg) begin
      ord_o = d_neg ? ORD_LT : ORD_GT;
    end else if (mag_lt ^ d_neg) begin
      ord_o = ORD_LT;
    end else begin
      ord_o = ORD_GT;
    end
  end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [EW+MW:0]    d_i,
  input  logic [EW+MW:0]    m_i,
  input  logic              cmp_zero_i,
  input  logic              sig_quiet_i,
  output logic              valid_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              invalid_o
);
  localparam int unsigned W = EW + MW + 1;

  logic [W-1:0]      m_eff;
  logic [1:0][W-1:0] ops;
  op_class_t [1:0]   cls;
  order_e            ord;
  logic              any_nan, raise_inv;
  logic [FLAG_W-1:0] flags_d;

  assign m_eff = cmp_zero_i ? '0 : m_i;
  assign ops[0] = d_i;
  assign ops[1] = m_eff;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(.EW(EW), .MW(MW)) i_cls (
      .word_i(ops[g]),
      .cls_o (cls[g])
    );
  end

  fcmp_order #(.W(W)) i_order (
    .d_i  (d_i),
    .m_i  (m_eff),
    .ord_o(ord)
  );

  always_comb begin
    any_nan   = cls[0].nan || cls[1].nan;
    raise_inv = cls[0].snan || cls[1].snan || (sig_quiet_i && any_nan);
    if (any_nan) begin
      flags_d = FL_UNO;
    end else begin
      unique case (ord)
        ORD_LT:  flags_d = FL_LT;
        ORD_EQ:  flags_d = FL_EQ;
        default: flags_d = FL_GT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      flags_o   <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        flags_o   <= flags_d;
        invalid_o <= raise_inv;
      end
    end
  end
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk
  import fcmp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [31:0]       d_i,
  input logic [31:0]       m_i,
  input logic              cmp_zero_i,
  input logic              sig_quiet_i,
  input logic              valid_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              invalid_o
);
  logic d_nan, d_snan;
  assign d_nan  = (&d_i[30:23]) && (|d_i[22:0]);
  assign d_snan = d_nan && !d_i[22];

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o == FL_LT || flags_o == FL_EQ || flags_o == FL_GT || flags_o == FL_UNO)); // R8
  AST_INV_ONLY_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && invalid_o) |-> flags_o == FL_UNO); // R8
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(flags_o) && $stable(invalid_o))); // R9
  AST_D_NAN_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && d_nan) |=> flags_o == FL_UNO); // R1
  AST_SNAN_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && d_snan) |=> invalid_o); // R2
endmodule

bind fcmp_flags fcmp_flags_chk i_fcmp_flags_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .d_i        (d_i),
  .m_i        (m_i),
  .cmp_zero_i (cmp_zero_i),
  .sig_quiet_i(sig_quiet_i),
  .valid_o    (valid_o),
  .flags_o    (flags_o),
  .invalid_o  (invalid_o)
);

// File: tb/test_fcmp_flags.sv
`timescale 1ns/1ps
module test_fcmp_flags;
  localparam logic [3:0] LT = 4'b1000, EQ = 4'b0110, GT = 4'b0010, UN = 4'b0011;
  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000;
  localparam logic [31:0] NONE = 32'hBF800000, NTWO = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h0, NZ = 32'h80000000;
  localparam logic [31:0] QNAN = 32'h7FC00000, SNAN = 32'h7F800001;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000, DEN = 32'h00000001;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [31:0] d_i = '0, m_i = '0;
  logic cmp_zero_i = 1'b0, sig_quiet_i = 1'b0;
  logic valid_o, invalid_o;
  logic [3:0] flags_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fcmp_flags i_fcmp_flags (
    .clk_i, .rst_ni, .valid_i, .d_i, .m_i, .cmp_zero_i, .sig_quiet_i,
    .valid_o, .flags_o, .invalid_o
  );

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  // one request, result sampled on the following negedge
  task automatic cmp(string req, logic [31:0] d, logic [31:0] m, logic z, logic sq,
                     logic [3:0] ef, logic ei);
    @(negedge clk_i);
    valid_i = 1'b1; d_i = d; m_i = m; cmp_zero_i = z; sig_quiet_i = sq;
    @(negedge clk_i);
    valid_i = 1'b0; m_i = 32'h7F800001;
    chk(req, {valid_o, flags_o, invalid_o}, {1'b1, ef, ei});
  endtask

  task automatic t_reset;
    #5;
    chk("R10", {valid_o, flags_o, invalid_o}, 6'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", {valid_o, flags_o, invalid_o}, 6'b0);
  endtask

  task automatic t_equal;
    cmp("R4", ONE, ONE, 0, 0, EQ, 0);
    cmp("R4", PZ, NZ, 0, 0, EQ, 0);
    cmp("R4", NINF, NINF, 0, 0, EQ, 0);
  endtask

  task automatic t_sign;
    cmp("R5", NONE, TWO, 0, 0, LT, 0);
    cmp("R5", ONE, NTWO, 0, 0, GT, 0);
    cmp("R5", NZ, DEN, 0, 0, LT, 0);
  endtask

  task automatic t_mag;
    cmp("R6", ONE, TWO, 0, 0, LT, 0);
    cmp("R6", TWO, ONE, 0, 0, GT, 0);
    cmp("R6", NONE, NTWO, 0, 0, GT, 0);
    cmp("R6", NTWO, NONE, 0, 0, LT, 0);
    cmp("R6", PINF, TWO, 0, 0, GT, 0);
    cmp("R6", NINF, ONE, 0, 0, LT, 0);
    cmp("R6", DEN, PZ, 0, 0, GT, 0);
  endtask

  task automatic t_nan;
    cmp("R1", QNAN, ONE, 0, 0, UN, 0);
    cmp("R1", ONE, QNAN, 0, 0, UN, 0);
    cmp("R3", QNAN, ONE, 0, 1, UN, 1);
    cmp("R3", ONE, 32'hFFC00001, 0, 1, UN, 1);
    cmp("R2", SNAN, ONE, 0, 0, UN, 1);
    cmp("R2", ONE, SNAN, 0, 0, UN, 1);
    cmp("R2", QNAN, SNAN, 0, 0, UN, 1);
  endtask

  task automatic t_zero;
    cmp("R7", ONE, QNAN, 1, 1, GT, 0);
    cmp("R7", NZ, SNAN, 1, 0, EQ, 0);
    cmp("R7", NONE, NTWO, 1, 0, LT, 0);
    cmp("R7", SNAN, ONE, 1, 0, UN, 1);
  endtask

  task automatic t_hold;
    cmp("R9", TWO, ONE, 0, 0, GT, 0);
    d_i = NONE; m_i = TWO;
    repeat (3) @(negedge clk_i);
    chk("R9", {valid_o, flags_o, invalid_o}, {1'b0, GT, 1'b0});
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_equal();
    t_sign();
    t_mag();
    t_nan();
    t_zero();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule